// File: doc/BRIEF.md
# Video-Aware DRAM Refresh Scheduler

This block makes sure that every row of a DRAM is refreshed once in each refresh period. A period is a fixed number of display lines. The display fetch already opens most rows during each scan line, and any opened row counts as refreshed. The block therefore records which rows the video side has touched. It issues explicit refresh requests only for the rows that are left over. The waveforms that actually refresh a row belong to the memory controller, which answers each request with an acknowledge.

A strobe marks the start of each line, and a line counter turns these strobes into periods. When the counter wraps, the touched-row map is cleared and the period outcome is recorded. In the last few lines of each period a sweep engine walks the row map from row 0 upward. It pauses outside horizontal blanking, and it raises one request at a time for each row still unmarked. Each acknowledged request marks its row as done.

The sweep engine is a four-state machine:
- IDLE waits for the sweep window together with blanking. When both hold, it moves to SCAN.
- SCAN tests the row under the pointer. A marked row moves the pointer on. An unmarked row moves the engine to REQ. The end of blanking returns it to IDLE. Moving past the last row takes it to DONE.
- REQ holds the request until an acknowledge arrives. The acknowledge returns the engine to SCAN, or to DONE after the last row.
- DONE idles until the period wraps.

A period wrap sends every state back to IDLE and rewinds the pointer.

Top module: `vref_refresh_sched`

## Requirements
- R1: After reset, ref_req and miss_err are 0 and the line count is 0.
- R2: The period ends on the LINES-th line_start strobe counted from reset or from the previous wrap, and that strobe starts a new period with an empty row map.
- R3: A row presented on row_addr with row_valid high during a period is not the subject of an explicit refresh request in that period.
- R4: Requests are issued one at a time, only for rows not yet touched or refreshed in the period, and in ascending row order starting from row 0.
- R5: A request is raised only while hblank is high. It may be raised only when the line count is at least LINES-SWEEP_LINES, counting from 0 at the period start.
- R6: Once raised, ref_req stays high with a stable ref_row until ref_ack is seen, even if hblank falls.
- R7: A request acknowledged on a clock edge is low in the following cycle, and its row counts as refreshed for the rest of the period.
- R8: A wrap withdraws any pending request, so ref_req is low in the cycle after the wrap edge.
- R9: At each wrap, miss_err is set to 1 if some row was neither touched nor refreshed in the ending period, and to 0 otherwise. It holds its value between wraps.
- R10: Before the sweep window, no request is raised even while hblank is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-cycle strobe at the start of each display line |
| hblank | input | 1 | High during horizontal blanking |
| row_valid | input | 1 | Video fetch opened the row on row_addr this cycle |
| row_addr | input | ROW_W | Row opened by the video fetch |
| ref_ack | input | 1 | Controller has performed the requested refresh |
| ref_req | output | 1 | Explicit refresh request |
| ref_row | output | ROW_W | Row to refresh while ref_req is high |
| miss_err | output | 1 | Previous period left at least one row unrefreshed |

## Verification
The checker assumes the following about the inputs. line_start is a single-cycle strobe. ref_ack is raised only while ref_req is high, and it lasts exactly one cycle. Blanking may fall while a request is pending. The stimulus follows these rules: it pulses ack for one cycle only after it sees a request at a falling edge, and it pulses the line strobe for one cycle. It deliberately drops blanking, and it wraps a period, while a request is still outstanding.

// File: rtl/vref_pkg.sv
package vref_pkg;
    typedef enum logic [1:0] {
        SW_IDLE,
        SW_SCAN,
        SW_REQ,
        SW_DONE
    } sweep_state_t;
endpackage

// File: rtl/vref_line_ctr.sv
module vref_line_ctr #(
    parameter int LINES       = 125,
    parameter int SWEEP_LINES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_start,
    output logic period_wrap,
    output logic in_window
);
    localparam int LINE_W    = (LINES > 1) ? $clog2(LINES) : 1;
    localparam int WIN_START = LINES - SWEEP_LINES;

    logic [LINE_W-1:0] line_cnt;

    assign period_wrap = line_start && (line_cnt == LINE_W'(LINES - 1));
    assign in_window   = (line_cnt >= LINE_W'(WIN_START));

    always_ff @(posedge clk) begin
        if (!rst_n)
            line_cnt <= '0;
        else if (period_wrap)
            line_cnt <= '0;
        else if (line_start)
            line_cnt <= line_cnt + 1'b1;
    end
endmodule

// File: rtl/vref_row_map.sv
module vref_row_map #(
    parameter int ROWS  = 256,
    parameter int ROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             vid_set,
    input  logic [ROW_W-1:0] vid_row,
    input  logic             ref_set,
    input  logic [ROW_W-1:0] ref_row,
    input  logic [ROW_W-1:0] look_row,
    output logic             look_hit,
    output logic             all_set
);
    logic [ROWS-1:0] marked;

    generate
        for (genvar g = 0; g < ROWS; g++) begin : g_bit
            logic hit_vid;
            logic hit_ref;
            assign hit_vid = vid_set && (vid_row == ROW_W'(g));
            assign hit_ref = ref_set && (ref_row == ROW_W'(g));
            always_ff @(posedge clk) begin
                if (!rst_n)
                    marked[g] <= 1'b0;
                else if (hit_vid || hit_ref)
                    marked[g] <= 1'b1;
                else if (clear)
                    marked[g] <= 1'b0;
            end
        end
    endgenerate

    assign look_hit = marked[look_row];
    assign all_set  = &marked;
endmodule

// File: rtl/vref_sweep_fsm.sv
module vref_sweep_fsm
    import vref_pkg::*;
#(
    parameter int ROWS  = 256,
    parameter int ROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             period_wrap,
    input  logic             in_window,
    input  logic             hblank,
    input  logic             look_hit,
    input  logic             ref_ack,
    output logic [ROW_W-1:0] ptr,
    output logic             ref_req,
    output logic             ref_accept
);
    sweep_state_t state, nxt_state;
    logic         adv;
    logic         ptr_last;

    assign ptr_last = (ptr == ROW_W'(ROWS - 1));

    always_comb begin
        nxt_state = state;
        adv       = 1'b0;
        unique case (state)
            SW_IDLE: begin
                if (in_window && hblank)
                    nxt_state = SW_SCAN;
            end
            SW_SCAN: begin
                if (!hblank) begin
                    nxt_state = SW_IDLE;
                end else if (look_hit) begin
                    adv = 1'b1;
                    if (ptr_last)
                        nxt_state = SW_DONE;
                end else begin
                    nxt_state = SW_REQ;
                end
            end
            SW_REQ: begin
                if (ref_ack) begin
                    adv       = 1'b1;
                    nxt_state = ptr_last ? SW_DONE : SW_SCAN;
                end
            end
            SW_DONE: begin
                nxt_state = SW_DONE;
            end
            default: nxt_state = SW_IDLE;
        endcase
        if (period_wrap)
            nxt_state = SW_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SW_IDLE;
            ptr   <= '0;
        end else begin
            state <= nxt_state;
            if (period_wrap)
                ptr <= '0;
            else if (adv && !ptr_last)
                ptr <= ptr + 1'b1;
        end
    end

    always_comb begin
        ref_req    = (state == SW_REQ);
        ref_accept = (state == SW_REQ) && ref_ack && !period_wrap;
    end
endmodule

// File: rtl/vref_refresh_sched.sv
module vref_refresh_sched #(
    parameter int ROWS        = 256,
    parameter int LINES       = 125,
    parameter int SWEEP_LINES = 8,
    parameter int ROW_W       = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start,
    input  logic             hblank,
    input  logic             row_valid,
    input  logic [ROW_W-1:0] row_addr,
    input  logic             ref_ack,
    output logic             ref_req,
    output logic [ROW_W-1:0] ref_row,
    output logic             miss_err
);
    logic             period_wrap;
    logic             in_window;
    logic             look_hit;
    logic             all_set;
    logic             ref_accept;
    logic [ROW_W-1:0] ptr;

    vref_line_ctr #(.LINES(LINES), .SWEEP_LINES(SWEEP_LINES)) u_lines (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .period_wrap(period_wrap),
        .in_window  (in_window)
    );

    vref_row_map #(.ROWS(ROWS), .ROW_W(ROW_W)) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (period_wrap),
        .vid_set (row_valid),
        .vid_row (row_addr),
        .ref_set (ref_accept),
        .ref_row (ptr),
        .look_row(ptr),
        .look_hit(look_hit),
        .all_set (all_set)
    );

    vref_sweep_fsm #(.ROWS(ROWS), .ROW_W(ROW_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_wrap(period_wrap),
        .in_window  (in_window),
        .hblank     (hblank),
        .look_hit   (look_hit),
        .ref_ack    (ref_ack),
        .ptr        (ptr),
        .ref_req    (ref_req),
        .ref_accept (ref_accept)
    );

    assign ref_row = ptr;

    always_ff @(posedge clk) begin
        if (!rst_n)
            miss_err <= 1'b0;
        else if (period_wrap)
            miss_err <= !all_set;
    end
endmodule

// File: rtl/vref_sched_chk.sv
module vref_sched_chk #(
    parameter int ROW_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hblank,
    input logic             ref_req,
    input logic             ref_ack,
    input logic [ROW_W-1:0] ref_row,
    input logic             miss_err,
    input logic             period_wrap,
    input logic             in_window
);
    // R5
    req_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_req) |-> $past(hblank));

    // R10
    req_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_req) |-> $past(in_window));

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && !ref_ack && !period_wrap) |=> (ref_req && $stable(ref_row)));

    // R7
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && ref_ack) |=> !ref_req);

    // R8
    wrap_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_wrap |=> !ref_req);

    // R9
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !period_wrap |=> $stable(miss_err));
endmodule

bind vref_refresh_sched vref_sched_chk #(.ROW_W(ROW_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hblank     (hblank),
    .ref_req    (ref_req),
    .ref_ack    (ref_ack),
    .ref_row    (ref_row),
    .miss_err   (miss_err),
    .period_wrap(period_wrap),
    .in_window  (in_window)
);

// File: tb/sim_vref_refresh_sched.sv
`timescale 1ns/1ps
module sim_vref_refresh_sched;
    localparam int ROWS  = 256;
    localparam int LINES = 10;
    localparam int SWL   = 3;
    localparam int ROW_W = 8;

    // each entry: modulus, residue, expected number of explicit requests
    localparam int NV = 6;
    localparam int VEC [NV][3] = '{
        '{43, 5, 6}, '{128, 0, 2}, '{64, 63, 4},
        '{256, 255, 1}, '{257, 256, 0}, '{1, 0, 256}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_start = 1'b0;
    logic hblank = 1'b0;
    logic row_valid = 1'b0;
    logic [ROW_W-1:0] row_addr = '0;
    logic ref_ack = 1'b0;
    logic ref_req;
    logic [ROW_W-1:0] ref_row;
    logic miss_err;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    vref_refresh_sched #(.ROWS(ROWS), .LINES(LINES), .SWEEP_LINES(SWL)) u0 (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .hblank(hblank),
        .row_valid(row_valid), .row_addr(row_addr), .ref_ack(ref_ack),
        .ref_req(ref_req), .ref_row(ref_row), .miss_err(miss_err)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_line(input int n);
        for (int i = 0; i < n; i++) begin
            line_start = 1'b1;
            step();
            line_start = 1'b0;
        end
    endtask

    task automatic touch(input int md, input int rs);
        for (int r = 0; r < ROWS; r++) begin
            if (r % md != rs) begin
                row_valid = 1'b1;
                row_addr  = ROW_W'(r);
                step();
                chk(ref_req == 1'b0, "R10 no request outside window", ref_req, 0);
            end
        end
        row_valid = 1'b0;
    endtask

    task automatic serve(input int md, input int rs, input int exp_cnt);
        int cnt = 0;
        int idle = 0;
        int nxt = 0;
        hblank = 1'b1;
        while (idle < 400) begin
            step();
            if (ref_req) begin
                while (nxt < ROWS && (nxt % md != rs)) nxt++;
                chk(int'(ref_row) == nxt, "R4 R3 requested row", ref_row, nxt);
                nxt++;
                ref_ack = 1'b1;
                step();
                ref_ack = 1'b0;
                chk(ref_req == 1'b0, "R7 request drops after ack", ref_req, 0);
                cnt++;
                idle = 0;
            end else begin
                idle++;
            end
        end
        hblank = 1'b0;
        chk(cnt == exp_cnt, "R4 request count", cnt, exp_cnt);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1
        chk(ref_req == 1'b0, "R1 reset ref_req", ref_req, 0);
        chk(miss_err == 1'b0, "R1 reset miss_err", miss_err, 0);

        // table-driven periods
        for (int v = 0; v < NV; v++) begin
            touch(VEC[v][0], VEC[v][1]);
            pulse_line(LINES - SWL);
            serve(VEC[v][0], VEC[v][1], VEC[v][2]);
            pulse_line(SWL);
            chk(miss_err == 1'b0, "R9 full coverage clears error", miss_err, 0);
        end

        // R10: blanking early in the period raises nothing
        hblank = 1'b1;
        for (int i = 0; i < 20; i++) begin
            step();
            chk(ref_req == 1'b0, "R10 blank before window", ref_req, 0);
        end
        hblank = 1'b0;
        pulse_line(LINES - SWL);
        hblank = 1'b1;
        repeat (4) step();
        chk(ref_req == 1'b1, "R5 request in window blank", ref_req, 1);
        chk(ref_row == 0, "R4 first row", ref_row, 0);
        // R6: blanking ends, request persists
        hblank = 1'b0;
        for (int i = 0; i < 5; i++) begin
            step();
            chk(ref_req == 1'b1 && ref_row == 0, "R6 request held", ref_req, 1);
        end
        ref_ack = 1'b1;
        step();
        ref_ack = 1'b0;
        for (int i = 0; i < 10; i++) begin
            step();
            chk(ref_req == 1'b0, "R5 no request outside blank", ref_req, 0);
        end
        pulse_line(SWL - 1);
        hblank = 1'b1;
        repeat (4) step();
        chk(ref_req == 1'b1 && ref_row == 1, "R7 next row after acked row", ref_row, 1);
        // R8: wrap with request pending
        pulse_line(1);
        chk(ref_req == 1'b0, "R8 wrap withdraws request", ref_req, 0);
        chk(miss_err == 1'b1, "R9 uncovered period flags", miss_err, 1);
        for (int i = 0; i < 10; i++) begin
            step();
            chk(ref_req == 1'b0, "R10 new period no request", ref_req, 0);
        end
        hblank = 1'b0;

        // R2 and R3: video covers all rows; error holds until the LINES-th strobe
        touch(ROWS + 1, ROWS);
        pulse_line(LINES - 1);
        chk(miss_err == 1'b1, "R2 no wrap before last strobe", miss_err, 1);
        pulse_line(1);
        chk(miss_err == 1'b0, "R2 R3 wrap on last strobe", miss_err, 0);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule